// File: doc/BRIEF.md
# Dual-Channel DAC Update Trigger Controller

This block produces the conversion-update strobes for two DAC channels. Each strobe lasts one clock cycle and tells that channel to latch its pending sample. A channel can be triggered by its own programmable pacer, by a software write, or by a routed source. For channel 0 the routed source is an asynchronous external clock pin, with a selectable active edge. For channel 1 it is whatever event source channel 0 currently has selected.

Each channel also enforces a programmable minimum gap between conversions. A trigger that arrives inside the gap is discarded rather than queued. Such a trigger sets a sticky per-channel error bit, which software clears by writing a one to it.

Configuration and status use a small register port: one write cycle per register, and a combinational read. Each pacer divider is wide enough to span from 100 kHz down to one update per 900 seconds with a 10 MHz system clock.

Top module: `dacTrigCtl`

## Requirements
- R1: While reset is asserted, and directly after it, both update strobes are low and the configuration register (address 0) and the status register (address 6) read as zero.
- R2: Writing address 5 with bit i set produces one update strobe on channel i. The strobe is high for exactly the cycle after the write edge, provided that channel's gap has elapsed.
- R3: Configuration bit 0 enables pacer 0 and bit 1 enables pacer 1. Each pacer's divisor is a 34-bit register (addresses 1 and 2) that reads back as written, so 9,000,000,000 is representable. With divisor N, and with the pacer as the selected source, strobes occur every N cycles, the first one N cycles after the enabling write edge. A divisor of 0 or 1 fires every cycle.
- R4: Clearing a pacer's enable bit stops its strobes and reloads its divider. Re-enabling it then yields the first strobe a full N cycles later.
- R5: Configuration bit 2 set selects the external clock pin as channel 0's event source, in place of pacer 0. The pin passes through a two-flop synchronizer.
- R6: Configuration bit 4 selects the active external edge: 0 for rising, 1 for falling. Each active edge yields exactly one trigger, and the opposite edge yields none.
- R7: Configuration bit 3 set makes channel 1 follow channel 0's selected event source (pacer 0 or external pin). It does not follow channel 0's software writes.
- R8: Minimum-gap values G (addresses 3 and 4) apply per channel. After an accepted trigger, triggers in the next G cycles are dropped with no strobe, and a trigger G+1 cycles later is accepted.
- R9: A dropped trigger sets that channel's status bit (bit i of address 6). The bit stays set until it is cleared.
- R10: Writing 1 to a status bit clears it, and writing 0 leaves it unchanged. A clear and a new drop in the same cycle leave the bit set.
- R11: A software trigger and a pacer trigger in the same cycle produce a single strobe and no error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (10 MHz nominal) |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Register write enable |
| wrAddr | input | 3 | Register write address |
| wrData | input | 34 | Register write data |
| rdAddr | input | 3 | Register read address |
| rdData | output | 34 | Register read data (combinational) |
| extClk | input | 1 | Asynchronous external conversion clock |
| updStrobe | output | 2 | One-cycle update strobe per channel |

## Verification
The assertions assume the following about the inputs:
- Write enable and address settle between clock edges, with at most one register written per cycle.
- The external pin holds each level long enough for the two-flop synchronizer to register it.

The stimulus meets these assumptions in three ways. Every input change happens on the falling clock edge. Each write is issued as an isolated single-cycle pulse. The external pin is toggled only after holding each level for ten cycles, so the properties on sticky errors, write-one clears and idle pacers see only clean, well-formed traffic.

// File: rtl/dacTrigPkg.sv
package dacTrigPkg;
  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] A_CFG   = 3'd0;
  localparam logic [ADDR_W-1:0] A_DIV0  = 3'd1;
  localparam logic [ADDR_W-1:0] A_DIV1  = 3'd2;
  localparam logic [ADDR_W-1:0] A_GAP0  = 3'd3;
  localparam logic [ADDR_W-1:0] A_GAP1  = 3'd4;
  localparam logic [ADDR_W-1:0] A_SWUPD = 3'd5;
  localparam logic [ADDR_W-1:0] A_STAT  = 3'd6;

  // Configuration word, packed MSB first: bit4 extFalling, bit3 ch1Follow,
  // bit2 ch0Ext, bits1:0 pacer enables.
  typedef struct packed {
    logic       extFalling;
    logic       ch1Follow;
    logic       ch0Ext;
    logic [1:0] pacerEn;
  } cfg_t;

  localparam int CFG_W = $bits(cfg_t);

  // Single-cycle strobes from control to datapath.
  typedef struct packed {
    logic [1:0] swHit;
    logic       extEdge;
    logic [1:0] errClr;
  } ctlStrb_t;
endpackage

// File: rtl/dacPacer.sv
module dacPacer #(
  parameter int DIV_W = 34
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             en,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;
  logic [DIV_W-1:0] reload;

  // Divisors 0 and 1 both mean "every cycle".
  assign reload = (div == '0) ? '0 : div - DIV_W'(1);
  assign tick   = en && (cnt == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt <= '0;
    end else if (!en) begin
      cnt <= reload;          // R4: idle pacer holds a full period
    end else if (cnt == '0) begin
      cnt <= reload;
    end else begin
      cnt <= cnt - DIV_W'(1);
    end
  end
endmodule

// File: rtl/dacTrigCtrl.sv
module dacTrigCtrl
  import dacTrigPkg::*;
#(
  parameter int DIV_W = 34,
  parameter int GAP_W = 16
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        wrEn,
  input  logic [ADDR_W-1:0]           wrAddr,
  input  logic [DIV_W-1:0]            wrData,
  input  logic [ADDR_W-1:0]           rdAddr,
  output logic [DIV_W-1:0]            rdData,
  input  logic                        extClk,
  input  logic [1:0]                  errFlag,
  output cfg_t                        cfg,
  output logic [1:0][DIV_W-1:0]       divVal,
  output logic [1:0][GAP_W-1:0]       gapVal,
  output ctlStrb_t                    strb
);
  logic [2:0] extPipe;
  logic       extNow;
  logic       extPrev;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfg    <= '0;
      divVal <= '0;
      gapVal <= '0;
    end else if (wrEn) begin
      case (wrAddr)
        A_CFG:  cfg       <= cfg_t'(wrData[CFG_W-1:0]);
        A_DIV0: divVal[0] <= wrData;
        A_DIV1: divVal[1] <= wrData;
        A_GAP0: gapVal[0] <= wrData[GAP_W-1:0];
        A_GAP1: gapVal[1] <= wrData[GAP_W-1:0];
        default: ;
      endcase
    end
  end

  // R5: two synchronizing flops, then one more for edge history.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) extPipe <= '0;
    else       extPipe <= {extPipe[1:0], extClk};
  end

  assign extNow  = extPipe[1];
  assign extPrev = extPipe[2];

  always_comb begin
    strb.swHit   = (wrEn && wrAddr == A_SWUPD) ? wrData[1:0] : 2'b00;
    strb.errClr  = (wrEn && wrAddr == A_STAT)  ? wrData[1:0] : 2'b00;
    // R6: polarity picks which transition counts.
    strb.extEdge = cfg.extFalling ? (extPrev & ~extNow) : (extNow & ~extPrev);
  end

  always_comb begin
    rdData = '0;
    case (rdAddr)
      A_CFG:   rdData[CFG_W-1:0] = cfg;
      A_DIV0:  rdData            = divVal[0];
      A_DIV1:  rdData            = divVal[1];
      A_GAP0:  rdData[GAP_W-1:0] = gapVal[0];
      A_GAP1:  rdData[GAP_W-1:0] = gapVal[1];
      A_STAT:  rdData[1:0]       = errFlag;
      default: rdData            = '0;
    endcase
  end
endmodule

// File: rtl/dacTrigPath.sv
module dacTrigPath
  import dacTrigPkg::*;
#(
  parameter int DIV_W = 34,
  parameter int GAP_W = 16
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  cfg_t                  cfg,
  input  logic [1:0][DIV_W-1:0] divVal,
  input  logic [1:0][GAP_W-1:0] gapVal,
  input  ctlStrb_t              strb,
  output logic [1:0]            updStrobe,
  output logic [1:0]            errFlag
);
  logic [1:0] pTick;
  logic       srcEvt0;
  logic       srcEvt1;
  logic [1:0] rawTrig;

  // R5/R7: asymmetric routing; channel 1 may follow channel 0's source event.
  assign srcEvt0 = cfg.ch0Ext    ? strb.extEdge : pTick[0];
  assign srcEvt1 = cfg.ch1Follow ? srcEvt0      : pTick[1];
  // R11: coincident triggers merge into one request.
  assign rawTrig = {srcEvt1, srcEvt0} | strb.swHit;

  for (genvar g = 0; g < 2; g++) begin : gen_ch
    logic [GAP_W-1:0] gapCnt;
    logic             gapIdle;
    logic             strbQ;
    logic             errQ;

    dacPacer #(.DIV_W(DIV_W)) u_pacer (
      .clk  (clk),
      .rstN (rstN),
      .en   (cfg.pacerEn[g]),
      .div  (divVal[g]),
      .tick (pTick[g])
    );

    assign gapIdle = (gapCnt == '0);

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        gapCnt <= '0;
        strbQ  <= 1'b0;
        errQ   <= 1'b0;
      end else begin
        strbQ <= rawTrig[g] & gapIdle;
        if (rawTrig[g] && gapIdle) gapCnt <= gapVal[g];      // R8
        else if (!gapIdle)         gapCnt <= gapCnt - GAP_W'(1);
        // R9/R10: drop sets, write-one clears, set wins.
        errQ <= (rawTrig[g] & ~gapIdle) | (errQ & ~strb.errClr[g]);
      end
    end

    assign updStrobe[g] = strbQ;
    assign errFlag[g]   = errQ;
  end
endmodule

// File: rtl/dacTrigCtl.sv
module dacTrigCtl
  import dacTrigPkg::*;
#(
  parameter int DIV_W = 34,
  parameter int GAP_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DIV_W-1:0]  wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [DIV_W-1:0]  rdData,
  input  logic              extClk,
  output logic [1:0]        updStrobe
);
  cfg_t                  cfg;
  logic [1:0][DIV_W-1:0] divVal;
  logic [1:0][GAP_W-1:0] gapVal;
  ctlStrb_t              strb;
  logic [1:0]            errFlag;

  dacTrigCtrl #(.DIV_W(DIV_W), .GAP_W(GAP_W)) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .wrEn    (wrEn),
    .wrAddr  (wrAddr),
    .wrData  (wrData),
    .rdAddr  (rdAddr),
    .rdData  (rdData),
    .extClk  (extClk),
    .errFlag (errFlag),
    .cfg     (cfg),
    .divVal  (divVal),
    .gapVal  (gapVal),
    .strb    (strb)
  );

  dacTrigPath #(.DIV_W(DIV_W), .GAP_W(GAP_W)) u_path (
    .clk       (clk),
    .rstN      (rstN),
    .cfg       (cfg),
    .divVal    (divVal),
    .gapVal    (gapVal),
    .strb      (strb),
    .updStrobe (updStrobe),
    .errFlag   (errFlag)
  );
endmodule

// File: rtl/dacTrigChk.sv
module dacTrigChk
  import dacTrigPkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              wrEn,
  input logic [ADDR_W-1:0] wrAddr,
  input logic [1:0]        wrBits,
  input logic [1:0]        updStrobe,
  input logic [1:0]        errFlag,
  input logic              pacerEn0,
  input logic              ch0Ext
);
  logic [1:0] clrHit;
  logic [1:0] swReq;

  assign clrHit = (wrEn && wrAddr == A_STAT)  ? wrBits : 2'b00;
  assign swReq  = (wrEn && wrAddr == A_SWUPD) ? wrBits : 2'b00;

  for (genvar g = 0; g < 2; g++) begin : gen_chk
    a_r9_sticky_err: assert property (@(posedge clk) disable iff (!rstN)
      errFlag[g] && !clrHit[g] |=> errFlag[g]);

    a_r10_clear_by_write: assert property (@(posedge clk) disable iff (!rstN)
      $fell(errFlag[g]) |-> $past(clrHit[g]));

    a_r8_drop_no_strobe: assert property (@(posedge clk) disable iff (!rstN)
      $rose(errFlag[g]) |-> !updStrobe[g]);
  end

  a_r4_idle_pacer_silent: assert property (@(posedge clk) disable iff (!rstN)
    $past(!pacerEn0 && !ch0Ext && !swReq[0]) |-> !updStrobe[0]);
endmodule

bind dacTrigCtl dacTrigChk u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .wrEn      (wrEn),
  .wrAddr    (wrAddr),
  .wrBits    (wrData[1:0]),
  .updStrobe (updStrobe),
  .errFlag   (errFlag),
  .pacerEn0  (cfg.pacerEn[0]),
  .ch0Ext    (cfg.ch0Ext)
);

// File: tb/tb_dacTrigCtl.sv
module tb_dacTrigCtl;
  localparam int DIV_W = 34;

  logic             clk = 1'b0;
  logic             rstN;
  logic             wrEn;
  logic [2:0]       wrAddr;
  logic [DIV_W-1:0] wrData;
  logic [2:0]       rdAddr;
  logic [DIV_W-1:0] rdData;
  logic             extClk;
  logic [1:0]       updStrobe;

  int errors = 0;
  int checks = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  dacTrigCtl dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData), .extClk(extClk), .updStrobe(updStrobe)
  );

  // Rows: divisor, gap, window, expected strobes, expected error bit
  localparam int VEC[5][5] = '{
    '{4, 0, 40, 10, 0},
    '{7, 3, 70, 10, 0},
    '{3, 5, 60, 10, 1},
    '{1, 0, 20, 20, 0},
    '{10, 9, 50, 5, 0}
  };

  task automatic check(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Called at a falling edge; the write is taken at the next rising edge.
  task automatic wr(input logic [2:0] a, input longint d);
    wrEn = 1'b1; wrAddr = a; wrData = DIV_W'(d);
    @(negedge clk);
    wrEn = 1'b0; wrData = '0;
  endtask

  task automatic rd(input logic [2:0] a, output longint v);
    rdAddr = a;
    #1;
    v = longint'(rdData);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic countStrb(input int n, output int c0, output int c1);
    c0 = 0; c1 = 0;
    repeat (n) begin
      @(negedge clk);
      if (updStrobe[0]) c0++;
      if (updStrobe[1]) c1++;
    end
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    longint v;
    int c0, c1;
    rstN = 1'b0; wrEn = 1'b0; wrAddr = '0; wrData = '0; rdAddr = '0; extClk = 1'b0;
    idle(3);
    check("R1 strobes in reset", updStrobe, 0);
    rstN = 1'b1;
    idle(2);
    check("R1 strobes after reset", updStrobe, 0);
    rd(3'd0, v); check("R1 config reads zero", v, 0);
    rd(3'd6, v); check("R1 status reads zero", v, 0);

    // R3: full 34-bit divisor range
    wr(3'd1, 64'd9_000_000_000);
    rd(3'd1, v); check("R3 divisor readback 900 s", v, 64'd9_000_000_000);

    // R2: software update, single cycle
    wr(3'd5, 1);
    check("R2 sw strobe ch0", updStrobe, 2'b01);
    idle(1);
    check("R2 sw strobe one cycle", updStrobe, 2'b00);
    wr(3'd5, 2);
    check("R2 sw strobe ch1", updStrobe, 2'b10);

    // R3/R8/R9: pacer vector table on channel 0
    foreach (VEC[i]) begin
      wr(3'd0, 0);
      wr(3'd3, VEC[i][1]);
      wr(3'd1, VEC[i][0]);
      idle(15);
      wr(3'd6, 3);
      wr(3'd0, 1);
      countStrb(VEC[i][2], c0, c1);
      check($sformatf("R3 R8 row %0d strobe count", i), c0, VEC[i][3]);
      check($sformatf("R3 row %0d ch1 silent", i), c1, 0);
      rd(3'd6, v);
      check($sformatf("R9 row %0d error bit", i), v & 1, VEC[i][4]);
    end
    wr(3'd0, 0);
    wr(3'd3, 0);

    // R4: disable mid-period, then re-enable gives a full period
    wr(3'd1, 5);
    idle(3);
    wr(3'd0, 1);
    idle(3);
    wr(3'd0, 0);
    countStrb(20, c0, c1);
    check("R4 disabled pacer silent", c0, 0);
    wr(3'd0, 1);
    countStrb(4, c0, c1);
    check("R4 no strobe before full period", c0, 0);
    countStrb(1, c0, c1);
    check("R4 strobe at full period", c0, 1);
    wr(3'd0, 0);

    // R11: software write coinciding with pacer tick
    wr(3'd1, 4);
    wr(3'd3, 2);
    idle(5);
    wr(3'd6, 3);
    wr(3'd0, 1);
    idle(3);
    wr(3'd5, 1);
    check("R11 merged strobe present", updStrobe[0], 1);
    countStrb(4, c0, c1);
    check("R11 one strobe per period", c0, 1);
    rd(3'd6, v); check("R11 no error on coincidence", v & 1, 0);
    wr(3'd0, 0);
    wr(3'd3, 0);
    idle(5);

    // R5/R6: external edge, rising then falling
    wr(3'd0, 4);
    extClk = 1'b1; countStrb(10, c0, c1);
    check("R5 R6 rising edge triggers", c0, 1);
    extClk = 1'b0; countStrb(10, c0, c1);
    check("R6 falling edge ignored when rising", c0, 0);
    wr(3'd0, 20);
    extClk = 1'b1; countStrb(10, c0, c1);
    check("R6 rising edge ignored when falling", c0, 0);
    extClk = 1'b0; countStrb(10, c0, c1);
    check("R6 falling edge triggers", c0, 1);

    // R7: channel 1 follows channel 0's source
    wr(3'd0, 12);
    extClk = 1'b1; countStrb(10, c0, c1);
    check("R7 ch1 follows ext ch0", c0 * 10 + c1, 11);
    extClk = 1'b0; idle(10);
    wr(3'd5, 1);
    check("R7 ch1 ignores ch0 sw", updStrobe, 2'b01);
    wr(3'd0, 8);
    wr(3'd1, 5);
    idle(3);
    wr(3'd0, 9);
    countStrb(20, c0, c1);
    check("R7 ch1 follows pacer0 ch0", c0, 4);
    check("R7 ch1 follows pacer0 ch1", c1, 4);
    wr(3'd0, 0);
    idle(5);

    // R9/R10: channel 1 error set and write-one clear
    wr(3'd6, 3);
    wr(3'd4, 10);
    wr(3'd5, 2);
    wr(3'd5, 2);
    check("R8 ch1 early trigger dropped", updStrobe[1], 0);
    rd(3'd6, v); check("R9 ch1 error only", v, 2);
    wr(3'd6, 0);
    rd(3'd6, v); check("R10 writing zero keeps flag", v, 2);
    wr(3'd6, 2);
    rd(3'd6, v); check("R10 writing one clears flag", v, 0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule